// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM device from its post-reset state to normal operation without software involvement. After a start pulse it checks the requested device geometry and waits a programmable power-up interval. It then issues the fixed bring-up command series to the memory command path, one command at a time. Each command appears on a mode/address/valid interface. Between commands the block holds off for a programmable gap, so that precharge, refresh and mode-register timing limits are met.

The command series is eleven steps long. First come a precharge of all banks and the loads of extended mode registers 2 and 3. Next the extended mode register is loaded with the DLL enabled, and the mode register with the DLL reset. A second precharge-all and two auto-refresh cycles follow. The final mode register load comes next, then the extended mode register twice more: once with the output-driver calibration default and once with the DLL enabled to leave calibration.

After the last command the block writes the normal-mode control word, which carries the refresh-rate field. It waits the power-up interval a second time and then raises `done`. Throughout the run it drives a packed control word holding the enable bit, the operating mode and the encoded geometry. A memory controller can take this word over unchanged.

Top module: `ddr2_init_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `cmdValid` and `geomErr` are 0, `ctrlWord` is 0 and `stepIdx` is 0, including when reset arrives in the middle of a sequence.
- R2: A start seen while idle with `rowBits` outside 11..14 or `colBits` outside 8..10 issues no command and leaves `busy` at 0. It sets `geomErr` to 1 from the next cycle. A start with valid geometry clears `geomErr`.
- R3: With power-up delay D, the first command's `cmdValid` appears after exactly D+1 cycles of `busy` without a command, counted from the clock edge that accepted the start.
- R4: The eleven commands carry these `cmdMode` values in order (precharge=1, auto-refresh=2, load-register=3): 1,3,3,3,3,1,2,2,3,3,3.
- R5: The eleven commands carry these `cmdAddr` values in order: 0x400, 0x04000000, 0x06000000, 0x02000400, 0x333, 0x400, 0, 0, 0x233, 0x02000780, 0x02000400. Every precharge has address bit 10 set.
- R6: `cmdValid` is high for exactly one cycle per command. With gap value G, exactly G+1 cycles without a command separate two consecutive commands.
- R7: While `cmdValid` is high, `ctrlWord` has bit 31 = 1, bits 30:28 = `cmdMode`, bits 25:24 = row-11, bits 21:20 = col-8, bits 17:16 = `dataSize`, and all other bits 0.
- R8: After the last command, `ctrlWord` holds the normal-mode word: bit 31 = 1, mode bits 30:28 = 0, the same geometry fields, and `refreshRate` in bits 15:13. The block then stays busy for exactly D+1 more cycles, after which `done` is 1 and `busy` is 0.
- R9: A start pulse while busy is ignored. The ordering, timing and values of the commands are unchanged, and `geomErr` stays 0.
- R10: While `cmdValid` is high, `stepIdx` equals the index (0..10) of the command. During the final wait it is 11.
- R11: `done` stays high while idle until the next accepted start, which clears it in the following cycle. `done` is never high while `busy` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a bring-up run (sampled when idle) |
| rowBits | input | 4 | Row address bit count, 11..14 |
| colBits | input | 4 | Column address bit count, 8..10 |
| dataSize | input | 2 | Data width code placed in the control word |
| refreshRate | input | 3 | Refresh-rate code merged into the normal-mode word |
| pwrupDelay | input | DLY_W | Power-up wait in cycles (0x20000 is typical) |
| gapCycles | input | GAP_W | Minimum idle cycles minus one between commands |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdMode | output | 3 | Operating mode of the current command |
| cmdAddr | output | 32 | Bank/row address of the current command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Initialization complete |
| geomErr | output | 1 | Last start was refused for bad geometry |
| stepIdx | output | 4 | Current command index |
| ctrlWord | output | 32 | Packed controller word |

## Verification
The assertions assume that `start`, geometry and timing inputs carry known values at each clock edge. They also assume that timing inputs matter only at the accepting edge, since the block latches them there. The counter assertion assumes the loaded delay fits the counter width, which the ports enforce. The stimulus draws geometry from the legal ranges, adds directed out-of-range values, and keeps the delays and gaps small. Start pulses during a run are placed inside gap windows, where they must be ignored.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int NUM_CMDS = 11;
  localparam int STEP_W   = $clog2(NUM_CMDS + 1);

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_PRECHG  = 3'd1,
    MODE_AREF    = 3'd2,
    MODE_LOADREG = 3'd3,
    MODE_MANREF  = 3'd4
  } opMode_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic acceptCfg;   // valid start: latch config, load power-up delay
    logic rejectCfg;   // start refused for geometry
    logic loadDelay;   // load counter with power-up delay
    logic loadGap;     // load counter with inter-command gap
    logic decCnt;      // count down
    logic setCmdMode;  // entering command issue: update mode field
    logic setNormal;   // last command issued: write normal-mode word
  } seqStrobe_t;

  function automatic opMode_e stepMode(input logic [STEP_W-1:0] s);
    case (s)
      4'd0, 4'd5: stepMode = MODE_PRECHG;
      4'd6, 4'd7: stepMode = MODE_AREF;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd9, 4'd10: stepMode = MODE_LOADREG;
      default:    stepMode = MODE_NORMAL;
    endcase
  endfunction

  function automatic logic [31:0] stepAddr(input logic [STEP_W-1:0] s);
    case (s)
      4'd0, 4'd5:  stepAddr = 32'h0000_0400;  // all-bank precharge, A10 high
      4'd1:        stepAddr = 32'h0400_0000;  // extended register 2
      4'd2:        stepAddr = 32'h0600_0000;  // extended register 3
      4'd3, 4'd10: stepAddr = 32'h0200_0400;  // extended register, DLL on
      4'd4:        stepAddr = 32'h0000_0333;  // mode register, DLL reset
      4'd8:        stepAddr = 32'h0000_0233;  // mode register, final
      4'd9:        stepAddr = 32'h0200_0780;  // calibration default
      default:     stepAddr = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] packCtrl(input logic en, input opMode_e m,
                                           input logic [1:0] r, input logic [1:0] c,
                                           input logic [1:0] d, input logic [2:0] rf);
    logic [31:0] w;
    w        = '0;
    w[31]    = en;
    w[30:28] = m;
    w[25:24] = r;
    w[21:20] = c;
    w[17:16] = d;
    w[15:13] = rf;
    return w;
  endfunction

endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              geomOk,
  input  logic              cntZero,
  output seqStrobe_t        strb,
  output logic              cmdValid,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] stepIdx
);

  typedef enum logic [2:0] {S_IDLE, S_PWRUP, S_ISSUE, S_GAP, S_FINAL} state_e;
  state_e state;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_CMDS - 1);
  wire lastStep = (stepIdx == LAST_STEP);

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE: if (start) begin
        if (geomOk) begin
          strb.acceptCfg = 1'b1;
          strb.loadDelay = 1'b1;
        end else begin
          strb.rejectCfg = 1'b1;
        end
      end
      S_PWRUP, S_GAP: begin
        if (cntZero) strb.setCmdMode = 1'b1;
        else         strb.decCnt     = 1'b1;
      end
      S_ISSUE: begin
        if (lastStep) begin
          strb.setNormal = 1'b1;
          strb.loadDelay = 1'b1;
        end else begin
          strb.loadGap = 1'b1;
        end
      end
      S_FINAL: if (!cntZero) strb.decCnt = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (strb.acceptCfg) begin
          state   <= S_PWRUP;
          stepIdx <= '0;
          done    <= 1'b0;
        end
        S_PWRUP, S_GAP: if (cntZero) state <= S_ISSUE;
        S_ISSUE: begin
          stepIdx <= stepIdx + 1'b1;
          state   <= lastStep ? S_FINAL : S_GAP;
        end
        S_FINAL: if (cntZero) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmdValid = (state == S_ISSUE);
  assign busy     = (state != S_IDLE);

  // R6
  cmd_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !cmdValid);
  // R10
  step_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> (stepIdx < STEP_W'(NUM_CMDS)));
  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (state inside {S_PWRUP, S_ISSUE, S_GAP})) |=> busy);

endmodule

// File: rtl/ddr2_init_dp.sv
module ddr2_init_dp
  import ddr2_init_pkg::*;
#(
  parameter int DLY_W = 20,
  parameter int GAP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [3:0]        rowBits,
  input  logic [3:0]        colBits,
  input  logic [1:0]        dataSize,
  input  logic [2:0]        refreshRate,
  input  logic [DLY_W-1:0]  pwrupDelay,
  input  logic [GAP_W-1:0]  gapCycles,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              cmdValid,
  output logic              geomOk,
  output logic              cntZero,
  output logic              geomErr,
  output logic [2:0]        cmdMode,
  output logic [31:0]       cmdAddr,
  output logic [31:0]       ctrlWord
);

  localparam int CNT_W = (DLY_W > GAP_W) ? DLY_W : GAP_W;

  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] dlyLat;
  logic [GAP_W-1:0] gapLat;
  logic [1:0]       rowEnc, colEnc, dsLat, rowLat, colLat;
  logic [2:0]       refLat;

  assign geomOk = (rowBits >= 4'd11) && (rowBits <= 4'd14) &&
                  (colBits >= 4'd8)  && (colBits <= 4'd10);
  // Within the legal ranges: row-11 == low two bits + 1 (mod 4), col-8 == low two bits
  assign rowEnc = rowBits[1:0] + 2'd1;
  assign colEnc = colBits[1:0];
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dlyLat   <= '0;
      gapLat   <= '0;
      rowLat   <= '0;
      colLat   <= '0;
      dsLat    <= '0;
      refLat   <= '0;
      geomErr  <= 1'b0;
      ctrlWord <= '0;
    end else begin
      if (strb.acceptCfg) begin
        dlyLat   <= pwrupDelay;
        gapLat   <= gapCycles;
        rowLat   <= rowEnc;
        colLat   <= colEnc;
        dsLat    <= dataSize;
        refLat   <= refreshRate;
        geomErr  <= 1'b0;
        ctrlWord <= packCtrl(1'b0, MODE_NORMAL, rowEnc, colEnc, dataSize, 3'd0);
      end
      if (strb.rejectCfg) geomErr <= 1'b1;

      if (strb.loadDelay)   cnt <= CNT_W'(strb.acceptCfg ? pwrupDelay : dlyLat);
      else if (strb.loadGap) cnt <= CNT_W'(gapLat);
      else if (strb.decCnt)  cnt <= cnt - 1'b1;

      if (strb.setCmdMode)
        ctrlWord <= packCtrl(1'b1, stepMode(stepIdx), rowLat, colLat, dsLat, 3'd0);
      if (strb.setNormal)
        ctrlWord <= packCtrl(1'b1, MODE_NORMAL, rowLat, colLat, dsLat, refLat);
    end
  end

  assign cmdMode = cmdValid ? stepMode(stepIdx) : MODE_NORMAL;
  assign cmdAddr = cmdValid ? stepAddr(stepIdx) : 32'h0;

  // R3
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strb.decCnt |-> !cntZero);
  // R7
  word_mode_chk: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> (ctrlWord[31] && (ctrlWord[30:28] == cmdMode)));
  // R5
  prechg_a10_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && (cmdMode == MODE_PRECHG)) |-> cmdAddr[10]);
  // R2
  accept_geom_chk: assert property (@(posedge clk) disable iff (rst)
    strb.acceptCfg |=> !geomErr);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int DLY_W = 20,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       rowBits,
  input  logic [3:0]       colBits,
  input  logic [1:0]       dataSize,
  input  logic [2:0]       refreshRate,
  input  logic [DLY_W-1:0] pwrupDelay,
  input  logic [GAP_W-1:0] gapCycles,
  output logic             cmdValid,
  output logic [2:0]       cmdMode,
  output logic [31:0]      cmdAddr,
  output logic             busy,
  output logic             done,
  output logic             geomErr,
  output logic [3:0]       stepIdx,
  output logic [31:0]      ctrlWord
);

  seqStrobe_t        strb;
  logic              geomOk, cntZero;
  logic [STEP_W-1:0] stepInt;

  ddr2_init_ctrl uCtrl (
    .clk(clk), .rst(rst), .start(start), .geomOk(geomOk), .cntZero(cntZero),
    .strb(strb), .cmdValid(cmdValid), .busy(busy), .done(done), .stepIdx(stepInt)
  );

  ddr2_init_dp #(.DLY_W(DLY_W), .GAP_W(GAP_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .rowBits(rowBits), .colBits(colBits),
    .dataSize(dataSize), .refreshRate(refreshRate), .pwrupDelay(pwrupDelay),
    .gapCycles(gapCycles), .stepIdx(stepInt), .cmdValid(cmdValid),
    .geomOk(geomOk), .cntZero(cntZero), .geomErr(geomErr),
    .cmdMode(cmdMode), .cmdAddr(cmdAddr), .ctrlWord(ctrlWord)
  );

  assign stepIdx = 4'(stepInt);

endmodule

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1, start = 1'b0;
  logic [3:0]  rowBits = 4'd12, colBits = 4'd9;
  logic [1:0]  dataSize = 2'd0;
  logic [2:0]  refreshRate = 3'd0;
  logic [19:0] pwrupDelay = 20'd0;
  logic [7:0]  gapCycles = 8'd0;
  logic        cmdValid, busy, done, geomErr;
  logic [2:0]  cmdMode;
  logic [31:0] cmdAddr, ctrlWord;
  logic [3:0]  stepIdx;

  always #4 clk = ~clk;  // 125 MHz

  ddr2_init_seq u0 (
    .clk(clk), .rst(rst), .start(start), .rowBits(rowBits), .colBits(colBits),
    .dataSize(dataSize), .refreshRate(refreshRate), .pwrupDelay(pwrupDelay),
    .gapCycles(gapCycles), .cmdValid(cmdValid), .cmdMode(cmdMode), .cmdAddr(cmdAddr),
    .busy(busy), .done(done), .geomErr(geomErr), .stepIdx(stepIdx), .ctrlWord(ctrlWord)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expMode(input int k);
    case (k)
      0, 5:    return 3'd1;
      6, 7:    return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic [31:0] expAddr(input int k);
    case (k)
      0, 5:  return 32'h400;
      1:     return 32'h0400_0000;
      2:     return 32'h0600_0000;
      3, 10: return 32'h0200_0400;
      4:     return 32'h333;
      8:     return 32'h233;
      9:     return 32'h0200_0780;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expWord(input int m, input int row, input int col,
                                          input int ds, input int rf);
    return (32'd1 << 31) | (32'(m) << 28) | (32'(row - 11) << 24) |
           (32'(col - 8) << 20) | (32'(ds) << 16) | (32'(rf) << 13);
  endfunction

  task automatic runSeq(input int row, input int col, input int ds, input int rf,
                        input int dly, input int gp, input bit poke);
    int idle;
    @(negedge clk);
    rowBits = 4'(row); colBits = 4'(col); dataSize = 2'(ds);
    refreshRate = 3'(rf); pwrupDelay = 20'(dly); gapCycles = 8'(gp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (row < 11 || row > 14 || col < 8 || col > 10) begin
      chk(geomErr == 1'b1, "R2", "geomErr after bad geometry", 32'(geomErr), 32'd1);
      chk(busy == 1'b0, "R2", "busy after bad geometry", 32'(busy), 32'd0);
      chk(cmdValid == 1'b0, "R2", "no command on bad geometry", 32'(cmdValid), 32'd0);
      return;
    end
    chk(geomErr == 1'b0, "R2", "geomErr cleared by valid start", 32'(geomErr), 32'd0);
    chk(done == 1'b0, "R11", "done cleared by accepted start", 32'(done), 32'd0);
    for (int k = 0; k < 11; k++) begin
      idle = 0;
      while (!cmdValid && idle < 100000) begin
        start = (poke && k == 4 && idle == 0);  // R9: start while busy
        if (start) rowBits = 4'd15;
        idle++;
        @(negedge clk);
        start = 1'b0;
        rowBits = 4'(row);
      end
      if (k == 0)
        chk(idle == dly + 1, "R3", "power-up wait cycles", 32'(idle), 32'(dly + 1));
      else
        chk(idle == gp + 1, "R6", "gap cycles", 32'(idle), 32'(gp + 1));
      chk(cmdMode == expMode(k), "R4", $sformatf("mode of cmd %0d", k),
          32'(cmdMode), 32'(expMode(k)));
      chk(cmdAddr == expAddr(k), "R5", $sformatf("address of cmd %0d", k),
          cmdAddr, expAddr(k));
      chk(stepIdx == 4'(k), "R10", "step index", 32'(stepIdx), 32'(k));
      chk(ctrlWord == expWord(expMode(k), row, col, ds, 0), "R7", "ctrl word in command",
          ctrlWord, expWord(expMode(k), row, col, ds, 0));
      @(negedge clk);
      chk(cmdValid == 1'b0, "R6", "valid lasts one cycle", 32'(cmdValid), 32'd0);
    end
    chk(ctrlWord == expWord(0, row, col, ds, rf), "R8", "normal-mode word",
        ctrlWord, expWord(0, row, col, ds, rf));
    chk(stepIdx == 4'd11, "R10", "step index in final wait", 32'(stepIdx), 32'd11);
    idle = 0;
    while (busy && idle < 100000) begin
      idle++;
      @(negedge clk);
    end
    chk(idle == dly + 1, "R8", "final wait cycles", 32'(idle), 32'(dly + 1));
    chk(done == 1'b1, "R8", "done after final wait", 32'(done), 32'd1);
    chk(geomErr == 1'b0, "R9", "geomErr after run", 32'(geomErr), 32'd0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R11", "done held while idle", 32'(done), 32'd1);
  endtask

  task automatic checkIdle(input string what);
    chk(busy == 1'b0, "R1", {what, " busy"}, 32'(busy), 32'd0);
    chk(done == 1'b0, "R1", {what, " done"}, 32'(done), 32'd0);
    chk(cmdValid == 1'b0, "R1", {what, " cmdValid"}, 32'(cmdValid), 32'd0);
    chk(geomErr == 1'b0, "R1", {what, " geomErr"}, 32'(geomErr), 32'd0);
    chk(ctrlWord == 32'h0, "R1", {what, " ctrlWord"}, ctrlWord, 32'h0);
    chk(stepIdx == 4'd0, "R1", {what, " stepIdx"}, 32'(stepIdx), 32'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkIdle("after reset");

    // directed corners
    runSeq(11, 8, 0, 0, 0, 0, 1'b0);
    runSeq(14, 10, 3, 7, 5, 3, 1'b1);
    runSeq(10, 9, 1, 2, 2, 1, 1'b0);   // R2: row below range
    runSeq(12, 9, 1, 5, 1, 1, 1'b0);   // R2: geomErr cleared again
    runSeq(15, 9, 1, 2, 2, 1, 1'b0);   // R2: row above range
    runSeq(12, 7, 1, 2, 2, 1, 1'b0);   // R2: col below range
    runSeq(12, 11, 1, 2, 2, 1, 1'b0);  // R2: col above range

    // R1: reset during a run
    @(negedge clk);
    rowBits = 4'd13; colBits = 4'd9; pwrupDelay = 20'd30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkIdle("after mid-run reset");

    // constrained random
    for (int n = 0; n < 30; n++) begin
      runSeq(11 + int'($urandom_range(0, 3)), 8 + int'($urandom_range(0, 2)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 20)), int'($urandom_range(0, 5)),
             bit'($urandom_range(0, 1)));
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule